// File: doc/BRIEF.md
# Roulette Play-Button Controller

This block steers a 37-position LED roulette from one push button. It brings the raw button level into the clock domain and looks at it only on a slow sampling enable, nominally 200 Hz. From that filtered level it picks one of four display modes: a post-reset mode that shows number 0, a spin mode in which the number generator runs, a hold mode that freezes the current number as the bet, and an attract mode that asks the display for a moving pattern.

A press moves the block to spin. A release moves it to hold. If no press is sampled for a set number of sampling ticks while in hold, the block leaves hold and enters attract. The default count is 36000, which is three minutes at 200 Hz. A press from hold or from attract starts a new spin. The number generator and the LED decoder sit outside this block and follow its mode outputs.

Top module: `roulette_play_ctrl`

## Requirements
- R1: During and after a synchronous reset, only `zeroEn` is high, until a press is sampled.
- R2: At all times exactly one of `zeroEn`, `spinEn`, `holdEn` and `attractEn` is high.
- R3: A sampled press moves the block to spin one cycle later, from the zero, hold or attract mode.
- R4: A sampled release during spin moves the block to hold one cycle later.
- R5: The button is read only on cycles where `sampleTick` is high. A pulse that does not overlap a sampling cycle after synchronisation has no effect on the mode.
- R6: The raw button passes through two synchroniser flops. A change cannot alter the mode outputs within three clock edges of the change.
- R7: After HOLD_TICKS sampling ticks in hold with no press, the block enters attract. Before that, it stays in hold.
- R8: A press sampled during attract returns the block to spin.
- R9: The zero mode never times out. It stays until a press is sampled.
- R10: The inactivity counter never exceeds HOLD_TICKS-1, and it restarts from zero on each entry to hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| btnRaw | input | 1 | Raw play-button level, 1 = pressed, asynchronous |
| sampleTick | input | 1 | One-cycle sampling enable (nominally 200 Hz) |
| zeroEn | output | 1 | Show number 0 (generator cleared) |
| spinEn | output | 1 | Number generator runs |
| holdEn | output | 1 | Freeze the displayed result |
| attractEn | output | 1 | Request the waiting animation |

## Verification
A button change travels through three registers before it is accepted: two synchroniser flops and the sampling register, which loads only on a tick. The mode register adds one more edge. A change is therefore due at most two cycles plus one tick period plus one cycle after the raw edge. The bench waits at least that long before it compares the mode, and it also checks that no mode change shows up within three edges of a raw change. Timeout checks are placed one tick period on each side of the HOLD_TICKS boundary, which absorbs the phase uncertainty between entering hold and the tick grid.

// File: rtl/roulette_ctl_pkg.sv
package roulette_ctl_pkg;

  typedef enum logic [1:0] {
    ST_ZERO    = 2'd0,
    ST_SPIN    = 2'd1,
    ST_HOLD    = 2'd2,
    ST_ATTRACT = 2'd3
  } rlState_t;

  typedef struct packed {
    logic clrTimer;
    logic runTimer;
  } rlStrb_t;

endpackage

// File: rtl/roulette_ctl_dp.sv
module roulette_ctl_dp
  import roulette_ctl_pkg::*;
#(
  parameter int HOLD_TICKS = 36000
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    btnRaw,
  input  logic    sampleTick,
  input  rlStrb_t strb,
  output logic    btnSmp,
  output logic    timeout
);
  localparam int CNT_W = (HOLD_TICKS > 2) ? $clog2(HOLD_TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_TICKS - 1);

  logic [1:0]       syncQ;
  logic [CNT_W-1:0] idleCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      syncQ  <= '0;
      btnSmp <= 1'b0;
    end else begin
      syncQ <= {syncQ[0], btnRaw};
      if (sampleTick) btnSmp <= syncQ[1];
    end
  end

  assign timeout = strb.runTimer && sampleTick && (idleCnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || strb.clrTimer) idleCnt <= '0;
    else if (strb.runTimer && sampleTick && idleCnt != LAST) idleCnt <= idleCnt + 1'b1;
  end

  // R5: the sampled level moves only on tick cycles
  assert_sample_on_tick_R5: assert property (@(posedge clk) disable iff (rst)
    !sampleTick |=> $stable(btnSmp));

  // R10: counter bounded
  assert_cnt_bound_R10: assert property (@(posedge clk) disable iff (rst)
    idleCnt <= LAST);

  // R10: cleared whenever not running in hold
  assert_cnt_clear_R10: assert property (@(posedge clk) disable iff (rst)
    strb.clrTimer |=> idleCnt == '0);

endmodule

// File: rtl/roulette_ctl_fsm.sv
module roulette_ctl_fsm
  import roulette_ctl_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    btnSmp,
  input  logic    timeout,
  output rlStrb_t strb,
  output logic    zeroEn,
  output logic    spinEn,
  output logic    holdEn,
  output logic    attractEn
);
  rlState_t state, nextState;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_ZERO:    if (btnSmp) nextState = ST_SPIN;
      ST_SPIN:    if (!btnSmp) nextState = ST_HOLD;
      ST_HOLD:    if (btnSmp) nextState = ST_SPIN;
                  else if (timeout) nextState = ST_ATTRACT;
      ST_ATTRACT: if (btnSmp) nextState = ST_SPIN;
      default:    nextState = ST_ZERO;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_ZERO;
    else     state <= nextState;
  end

  assign zeroEn    = (state == ST_ZERO);
  assign spinEn    = (state == ST_SPIN);
  assign holdEn    = (state == ST_HOLD);
  assign attractEn = (state == ST_ATTRACT);

  assign strb.runTimer = (state == ST_HOLD);
  assign strb.clrTimer = (state != ST_HOLD);

  // R2: one mode at a time
  assert_one_mode_R2: assert property (@(posedge clk) disable iff (rst)
    $countones({zeroEn, spinEn, holdEn, attractEn}) == 1);

  // R3: sampled press starts a spin
  assert_press_spin_R3: assert property (@(posedge clk) disable iff (rst)
    btnSmp |=> spinEn);

  // R4: sampled release in spin freezes the result
  assert_release_hold_R4: assert property (@(posedge clk) disable iff (rst)
    spinEn && !btnSmp |=> holdEn);

  // R8: attract left only for spin
  assert_attract_exit_R8: assert property (@(posedge clk) disable iff (rst)
    attractEn |=> attractEn || spinEn);

  // R9: zero mode has no timeout
  assert_zero_stays_R9: assert property (@(posedge clk) disable iff (rst)
    zeroEn && !btnSmp |=> zeroEn);

endmodule

// File: rtl/roulette_play_ctrl.sv
module roulette_play_ctrl
  import roulette_ctl_pkg::*;
#(
  parameter int HOLD_TICKS = 36000
) (
  input  logic clk,
  input  logic rst,
  input  logic btnRaw,
  input  logic sampleTick,
  output logic zeroEn,
  output logic spinEn,
  output logic holdEn,
  output logic attractEn
);
  rlStrb_t strb;
  logic    btnSmp;
  logic    timeout;

  roulette_ctl_dp #(.HOLD_TICKS(HOLD_TICKS)) dp_i (
    .clk(clk), .rst(rst), .btnRaw(btnRaw), .sampleTick(sampleTick),
    .strb(strb), .btnSmp(btnSmp), .timeout(timeout)
  );

  roulette_ctl_fsm fsm_i (
    .clk(clk), .rst(rst), .btnSmp(btnSmp), .timeout(timeout),
    .strb(strb), .zeroEn(zeroEn), .spinEn(spinEn),
    .holdEn(holdEn), .attractEn(attractEn)
  );

endmodule

// File: tb/roulette_play_ctrl_tb_top.sv
`timescale 1ns/1ps
module roulette_play_ctrl_tb_top;
  localparam int TICKP  = 8;
  localparam int HOLD   = 20;
  localparam int SETTLE = 2 + TICKP + 2;
  localparam logic [3:0] M_ZERO = 4'b0001, M_SPIN = 4'b0010,
                         M_HOLD = 4'b0100, M_ATTR = 4'b1000;

  logic clk = 1'b0, rst = 1'b1, btnRaw = 1'b0, sampleTick = 1'b0;
  logic zeroEn, spinEn, holdEn, attractEn;
  int   checks = 0, errors = 0, tickCnt = 0;
  bit   done = 0;

  always #2.5 clk = ~clk;

  roulette_play_ctrl #(.HOLD_TICKS(HOLD)) dut_i (
    .clk(clk), .rst(rst), .btnRaw(btnRaw), .sampleTick(sampleTick),
    .zeroEn(zeroEn), .spinEn(spinEn), .holdEn(holdEn), .attractEn(attractEn)
  );

  always @(negedge clk) begin
    tickCnt    <= (tickCnt == TICKP - 1) ? 0 : tickCnt + 1;
    sampleTick <= (tickCnt == TICKP - 1);
  end

  function automatic logic [3:0] modeAfterWait(int waitTicks);
    return (waitTicks >= HOLD + 2) ? M_ATTR : M_HOLD;
  endfunction

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(string req, logic [3:0] exp);
    logic [3:0] act;
    act = {attractEn, holdEn, spinEn, zeroEn};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: mode actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int w;
    void'($urandom(32'h5eed_0037));
    cyc(4);
    chk("R1", M_ZERO);
    rst = 1'b0;
    cyc(HOLD * TICKP + 40);
    chk("R9", M_ZERO);

    // R6: latency through synchroniser
    btnRaw = 1'b1;
    cyc(3);
    chk("R6", M_ZERO);
    cyc(SETTLE);
    chk("R3", M_SPIN);
    btnRaw = 1'b0;
    cyc(SETTLE);
    chk("R4", M_HOLD);
    cyc((HOLD - 1) * TICKP - SETTLE);
    chk("R7", M_HOLD);
    cyc(2 * TICKP + 4);
    chk("R7", M_ATTR);
    btnRaw = 1'b1;
    cyc(SETTLE);
    chk("R8", M_SPIN);
    btnRaw = 1'b0;
    cyc(SETTLE);
    chk("R4", M_HOLD);

    // R5: one-cycle pulse right after a sampling edge is missed
    while (sampleTick !== 1'b1) @(negedge clk);
    @(negedge clk);
    btnRaw = 1'b1;
    @(negedge clk);
    btnRaw = 1'b0;
    cyc(2 * TICKP);
    chk("R5", M_HOLD);
    // R10: timer restarts on new hold entry
    btnRaw = 1'b1;
    cyc(SETTLE);
    chk("R3", M_SPIN);
    btnRaw = 1'b0;
    cyc(SETTLE);
    cyc((HOLD - 1) * TICKP - SETTLE);
    chk("R10", M_HOLD);

    // random press / wait sequences
    for (int k = 0; k < 25; k++) begin
      btnRaw = 1'b1;
      cyc(SETTLE + ($urandom % 5) * TICKP);
      chk("R3", M_SPIN);
      chk("R2", M_SPIN);
      btnRaw = 1'b0;
      w = ($urandom % 2) ? 2 + ($urandom % (HOLD - 4)) : HOLD + 2 + ($urandom % 4);
      cyc(w * TICKP);
      chk(w >= HOLD + 2 ? "R7" : "R4", modeAfterWait(w));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule